// File: doc/BRIEF.md
# Shared Mailbox Aperture with Ownership Handoff

This block holds a small mailbox of eight 32-bit dwords (256 bits in total) that two agents share. The requester side fills the payload dwords and then writes the header in the last dword, index 7. The responder side reads the request, writes its answer and finishes by writing its own header back to dword 7. Bit 31 of dword 7 records who may write. When it is set, the responder owns the mailbox. When it is clear, the requester owns it. The hardware drives that bit itself on every header write, whatever value the writer supplies in that position.

Dword 7 also carries the rest of the protocol header, which this block stores without interpreting it. The fields are:

- message type in bits 2:0
- version in bits 5:3
- direction in bit 7 (0 request, 1 response)
- a status byte in bits 15:8
- a reset-request flag in bit 24
- the owner flag in bit 31

A function-reset input makes the requester's view of the aperture read as all ones. It leaves the stored contents untouched.

Both ports are simple: a write enable, a dword index and write data, plus read data that follows the index combinationally. Only the side that currently owns the mailbox can change it. Requester writes made while the responder owns the mailbox are dropped, and each dropped write is reported by a one-cycle flag.

Top module: `mbox_aperture`

## Requirements
- R1: After power-on reset (rstN low) every dword reads as 0 on both ports, ownedByResponder is 0 and reqWriteIgnored is 0.
- R2: While the requester owns the mailbox, a requester write to dword 0 to 6 stores the full 32-bit value. From the next cycle that value is visible at that index on both read ports.
- R3: While the requester owns the mailbox, a requester write to dword 7 stores bits 30:0 of the data and sets bit 31. Bit 31 is set whatever the written bit 31 was, so ownedByResponder is 1 from the next cycle.
- R4: While the responder owns the mailbox, a responder write to dword 7 stores bits 30:0 of the data and clears bit 31. Bit 31 is cleared whatever the written bit 31 was, so ownedByResponder is 0 from the next cycle.
- R5: A responder write to any dword while the requester owns the mailbox has no effect on contents or ownership. Ownership changes only through the writes of R3 and R4.
- R6: A requester write to any dword (0 to 7) while the responder owns the mailbox leaves every dword and the ownership unchanged. reqWriteIgnored is 1 in the cycle after each such write and 0 after any other cycle.
- R7: While the responder owns the mailbox, a responder write to dword 0 to 6 stores the full 32-bit value.
- R8: While funcReset is 1, reqRdData is 0xFFFFFFFF for every index, and rspRdData still shows the stored contents. Once funcReset returns to 0, the requester reads the unchanged stored contents again.
- R9: ownedByResponder always equals bit 31 of dword 7 as read on the responder port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| funcReset | input | 1 | Function-reset state: forces requester reads to all ones |
| reqWrEn | input | 1 | Requester write enable |
| reqAddr | input | 3 | Requester dword index, used for both read and write |
| reqWrData | input | 32 | Requester write data |
| reqRdData | output | 32 | Requester read data for reqAddr |
| rspWrEn | input | 1 | Responder write enable |
| rspAddr | input | 3 | Responder dword index, used for both read and write |
| rspWrData | input | 32 | Responder write data |
| rspRdData | output | 32 | Responder read data for rspAddr |
| ownedByResponder | output | 1 | Owner flag (bit 31 of dword 7) |
| reqWriteIgnored | output | 1 | Pulses for one cycle after each dropped requester write |

## Verification
The bench writes every index from each side, once while that side owns the mailbox and once while it does not.

- A design that let the non-owner write would corrupt payload or header.
- One that decoded the header index wrongly would hand off ownership on a payload write.
- Header writes are made with bit 31 both set and clear in the data. A design that stored the written bit instead of forcing it would leave ownership stuck.
- A sweep of every index under funcReset catches an override that reaches only some indices or the responder side. Reading everything back after funcReset is released catches an override that altered the storage.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DwordW   = 32;
  localparam int NumDword = 8;
  localparam int AddrW    = $clog2(NumDword);
  localparam int LastIdx  = NumDword - 1;
  localparam int OwnerBit = DwordW - 1;

  typedef struct packed {
    logic              wrEn;
    logic              fromReq;
    logic [AddrW-1:0]  wrAddr;
    logic [DwordW-1:0] wrData;
  } wrStrobe_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqWrEn,
  input  logic [AddrW-1:0]  reqAddr,
  input  logic [DwordW-1:0] reqWrData,
  input  logic              rspWrEn,
  input  logic [AddrW-1:0]  rspAddr,
  input  logic [DwordW-1:0] rspWrData,
  input  logic              ownerBit,
  output wrStrobe_t         strb,
  output logic              reqIgnored
);
  logic reqAccept;
  logic rspAccept;

  // Only the current owner may write, so the two accepts never coincide.
  assign reqAccept = reqWrEn && !ownerBit;
  assign rspAccept = rspWrEn && ownerBit;

  always_comb begin
    strb.wrEn    = reqAccept || rspAccept;
    strb.fromReq = reqAccept;
    strb.wrAddr  = reqAccept ? reqAddr   : rspAddr;
    strb.wrData  = reqAccept ? reqWrData : rspWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) reqIgnored <= 1'b0;
    else       reqIgnored <= reqWrEn && ownerBit;
  end

  p_req_handoff_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqWrEn && !ownerBit && reqAddr == AddrW'(LastIdx)) |=> ownerBit);

  p_rsp_handback_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rspWrEn && ownerBit && rspAddr == AddrW'(LastIdx)) |=> !ownerBit);

  p_drop_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqWrEn && ownerBit) |=> (reqIgnored && ownerBit));
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strb,
  input  logic              funcReset,
  input  logic [AddrW-1:0]  reqRdAddr,
  input  logic [AddrW-1:0]  rspRdAddr,
  output logic [DwordW-1:0] reqRdData,
  output logic [DwordW-1:0] rspRdData,
  output logic              ownerBit
);
  logic [DwordW-1:0] store [NumDword];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NumDword; i++) store[i] <= '0;
    end else if (strb.wrEn) begin
      for (int i = 0; i < NumDword; i++) begin
        if (strb.wrAddr == AddrW'(i)) begin
          if (i == LastIdx) store[i] <= {strb.fromReq, strb.wrData[OwnerBit-1:0]};
          else              store[i] <= strb.wrData;
        end
      end
    end
  end

  assign ownerBit  = store[LastIdx][OwnerBit];
  assign rspRdData = store[rspRdAddr];
  assign reqRdData = funcReset ? '1 : store[reqRdAddr];

  p_owner_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrEn || strb.wrAddr != AddrW'(LastIdx)) |=> $stable(ownerBit));

  p_ones_override_r8: assert property (@(posedge clk) disable iff (!rstN)
    (funcReset && reqRdAddr == rspRdAddr) |-> (reqRdData == '1 && rspRdData == store[rspRdAddr]));
endmodule

// File: rtl/mbox_aperture.sv
module mbox_aperture
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              funcReset,
  input  logic              reqWrEn,
  input  logic [AddrW-1:0]  reqAddr,
  input  logic [DwordW-1:0] reqWrData,
  output logic [DwordW-1:0] reqRdData,
  input  logic              rspWrEn,
  input  logic [AddrW-1:0]  rspAddr,
  input  logic [DwordW-1:0] rspWrData,
  output logic [DwordW-1:0] rspRdData,
  output logic              ownedByResponder,
  output logic              reqWriteIgnored
);
  wrStrobe_t strb;
  logic      ownerBit;

  mbox_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqWrEn(reqWrEn), .reqAddr(reqAddr), .reqWrData(reqWrData),
    .rspWrEn(rspWrEn), .rspAddr(rspAddr), .rspWrData(rspWrData),
    .ownerBit(ownerBit), .strb(strb), .reqIgnored(reqWriteIgnored)
  );

  mbox_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .funcReset(funcReset),
    .reqRdAddr(reqAddr), .rspRdAddr(rspAddr),
    .reqRdData(reqRdData), .rspRdData(rspRdData), .ownerBit(ownerBit)
  );

  assign ownedByResponder = ownerBit;

  p_owner_visible_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspAddr == AddrW'(LastIdx)) |-> (ownedByResponder == rspRdData[OwnerBit]));
endmodule

// File: tb/mbox_aperture_tb.sv
module mbox_aperture_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        funcReset = 1'b0;
  logic        reqWrEn = 1'b0;
  logic [2:0]  reqAddr = '0;
  logic [31:0] reqWrData = '0;
  logic [31:0] reqRdData;
  logic        rspWrEn = 1'b0;
  logic [2:0]  rspAddr = '0;
  logic [31:0] rspWrData = '0;
  logic [31:0] rspRdData;
  logic        ownedByResponder;
  logic        reqWriteIgnored;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;
  logic [31:0] mdl [8];
  bit mdlOwn = 1'b0;

  always #10 clk = ~clk;

  mbox_aperture u_dut (
    .clk(clk), .rstN(rstN), .funcReset(funcReset),
    .reqWrEn(reqWrEn), .reqAddr(reqAddr), .reqWrData(reqWrData), .reqRdData(reqRdData),
    .rspWrEn(rspWrEn), .rspAddr(rspAddr), .rspWrData(rspWrData), .rspRdData(rspRdData),
    .ownedByResponder(ownedByResponder), .reqWriteIgnored(reqWriteIgnored)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int a, int r);
    return (32'h9E3779B9 * (a + 1)) ^ (r << 12) ^ (32'h0101_0000 * r);
  endfunction

  // Reads every index on both ports and compares against the model (R9 owner too).
  task automatic checkAll(string tag);
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      reqAddr = 3'(a); rspAddr = 3'(a);
      #1;
      check({tag, " req read"}, reqRdData, mdl[a]);
      check({tag, " rsp read"}, rspRdData, mdl[a]);
    end
    check({tag, " R9 owner"}, {31'd0, ownedByResponder}, {31'd0, mdlOwn});
  endtask

  task automatic reqWrite(string tag, int a, logic [31:0] d);
    bit expIgn;
    @(negedge clk);
    reqWrEn = 1'b1; reqAddr = 3'(a); reqWrData = d;
    expIgn = mdlOwn;
    if (!mdlOwn) begin
      if (a == 7) begin mdl[7] = {1'b1, d[30:0]}; mdlOwn = 1'b1; end
      else mdl[a] = d;
    end
    @(negedge clk);
    reqWrEn = 1'b0;
    check({tag, " ignored flag"}, {31'd0, reqWriteIgnored}, {31'd0, expIgn});
  endtask

  task automatic rspWrite(int a, logic [31:0] d);
    @(negedge clk);
    rspWrEn = 1'b1; rspAddr = 3'(a); rspWrData = d;
    if (mdlOwn) begin
      if (a == 7) begin mdl[7] = {1'b0, d[30:0]}; mdlOwn = 1'b0; end
      else mdl[a] = d;
    end
    @(negedge clk);
    rspWrEn = 1'b0;
    check("R6 flag quiet on responder write", {31'd0, reqWriteIgnored}, 32'd0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int a = 0; a < 8; a++) mdl[a] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkAll("R1 reset");
    check("R1 flag", {31'd0, reqWriteIgnored}, 32'd0);

    for (int r = 0; r < 4; r++) begin
      // R2: requester payload writes while it owns
      for (int a = 0; a < 7; a++) reqWrite("R2", a, pat(a, r));
      checkAll("R2 payload");
      // R5: responder writes while requester owns are dropped
      for (int a = 0; a < 8; a++) rspWrite(a, ~pat(a, r + 7));
      checkAll("R5 responder dropped");
      // R3: header write hands over; written bit 31 alternates
      reqWrite("R3", 7, {r[0], pat(7, r)[30:0]});
      checkAll("R3 handoff");
      // R6: every requester write now dropped and flagged
      for (int a = 0; a < 8; a++) reqWrite("R6", a, pat(a, r + 20));
      checkAll("R6 dropped");
      // R7: responder payload writes
      for (int a = 0; a < 7; a++) rspWrite(a, pat(a, r + 40));
      checkAll("R7 responder payload");
      // R8: function-reset override sweep
      @(negedge clk); funcReset = 1'b1;
      for (int a = 0; a < 8; a++) begin
        @(negedge clk);
        reqAddr = 3'(a); rspAddr = 3'(a);
        #1;
        check("R8 req all ones", reqRdData, 32'hFFFF_FFFF);
        check("R8 rsp unaffected", rspRdData, mdl[a]);
      end
      @(negedge clk); funcReset = 1'b0;
      checkAll("R8 contents kept");
      // R4: responder header hands back; written bit 31 alternates
      rspWrite(7, {~r[0], pat(7, r + 60)[30:0]});
      checkAll("R4 handback");
    end
    finishRun();
  end
endmodule